// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block collects interrupt requests from five sources of a small microcontroller: two external pins, a timer/event counter overflow, a periodic time-base tick and a real-time-clock tick. It keeps an enable bit and a request flag for each source, plus one global enable. All of these bits are visible and writable through two 8-bit control/status registers on a simple register bus.

When at least one enabled source has its flag set, the global enable is on and the return stack has room, the controller raises a request toward the CPU. The request carries the fixed vector address of the winning source. The CPU answers with a one-cycle acknowledge. On that acknowledge the controller clears the winning source's flag and the global enable, so handlers never nest until software turns the global enable back on.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every enable bit, every flag and the global enable are 0. `irq_req` is 0, and reads of both registers return 0.
- R2: Register at address 0x0B: bit 0 is the global enable, bits 1/2/3 are the enables of external 0/external 1/timer, and bits 4/5/6 are the flags of external 0/external 1/timer. Bit 7 reads 0. A write sets all seven bits from the written data.
- R3: Register at address 0x1E: bits 0/1 are the enables of time base/real-time clock and bits 4/5 are their flags. Bits 2, 3, 6 and 7 read 0. Reads of any other address return 0, and writes to any other address change nothing.
- R4: `irq_req` is 1 exactly when the global enable is 1, `stack_full` is 0, and at least one source has both its flag and its enable set. A 1 stands for enabled or active.
- R5: While `irq_req` is 1, `irq_vec` is the vector of the pending-and-enabled source with the lowest vector. The vectors are 0x04 (external 0), 0x08 (external 1), 0x0C (timer), 0x10 (time base) and 0x14 (real-time clock).
- R6: An `irq_ack` high while `irq_req` is 1 clears the winning source's flag and the global enable at that clock edge. All other flags and enables are kept. An `irq_ack` while `irq_req` is 0 has no effect.
- R7: A one-cycle pulse on `tmr_ovf`, `tb_tick` or `rtc_tick` sets the matching flag at that clock edge, whatever the enables are.
- R8: Each external pin passes through a two-flop synchronizer. A high-to-low change on the pin sets its flag on the third rising edge after the change. A low-to-high change sets nothing.
- R9: If a hardware set event for a flag falls in the same cycle as a software write of 0 to that flag, or as an acknowledge that clears it, the flag ends up 1.
- R10: Software writing 1 to a flag sets it, and that request is then served exactly like a hardware one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 2 | External interrupt pins, asynchronous, falling-edge active |
| tmr_ovf | input | 1 | Timer overflow strobe |
| tb_tick | input | 1 | Time-base tick strobe |
| rtc_tick | input | 1 | Real-time-clock tick strobe |
| stack_full | input | 1 | Return stack full, blocks service |
| reg_addr | input | 8 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on address |
| irq_req | output | 1 | Vector request to CPU |
| irq_vec | output | 8 | Vector address of the winning source |
| irq_ack | input | 1 | One-cycle acknowledge from CPU |

## Verification
Two functions can act on the same flag in one cycle. The first is a hardware set from a strobe. The second is a clear, which comes either from a software register write of 0 or from an acknowledge of that very source. The bench provokes both collisions on the timer flag: it pulses `tmr_ovf` in the same cycle as a register write of 0, and again in the same cycle as `irq_ack`. It then reads the register back and judges the run correct only if the flag stayed set. In the acknowledge collision the global enable must still fall. Around these cases, the bench sweeps every combination of the five flags and five enables, with the stack both free and full, and compares request, vector and readback against arithmetic expectations.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC    = 5;
  localparam int SRC_EX0 = 0;
  localparam int SRC_EX1 = 1;
  localparam int SRC_TMR = 2;
  localparam int SRC_TB  = 3;
  localparam int SRC_RTC = 4;
  localparam int IDX_W   = $clog2(NSRC);
endpackage

// File: rtl/irqc_pin_sync.sv
module irqc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sq, sq_n;
  logic              last_q;

  always_comb begin
    sq_n[0] = pin;
    for (int i = 1; i < STAGES; i++) sq_n[i] = sq[i-1];
  end

  // idle level of the pins is high; reset to it so no false edge appears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq     <= '1;
      last_q <= 1'b1;
    end else begin
      sq     <= sq_n;
      last_q <= sq[STAGES-1];
    end
  end

  assign fall = last_q & ~sq[STAGES-1];
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end

  assign any   = |pend;
  assign grant = pend & (~pend + N'(1));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter int          SYNC_STG  = 2,
  parameter int          VEC_BASE  = 4,
  parameter int          VEC_STEP  = 4,
  parameter logic [7:0]  CTL0_ADDR = 8'h0B,
  parameter logic [7:0]  CTL1_ADDR = 8'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ext_pin,
  input  logic              tmr_ovf,
  input  logic              tb_tick,
  input  logic              rtc_tick,
  input  logic              stack_full,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_req,
  output logic [DATA_W-1:0] irq_vec,
  input  logic              irq_ack
);
  localparam int NEXT = 2;

  logic            gie_q, gie_n;
  logic [NSRC-1:0] en_q, en_n;
  logic [NSRC-1:0] flag_q, flag_n, flag_sw;
  logic [NSRC-1:0] hw_set, pend, grant;
  logic [NEXT-1:0] ext_fall;
  logic [IDX_W-1:0] win_idx;
  logic            any_pend, wr0, wr1, take, upd_ctl;

  genvar g;
  generate
    for (g = 0; g < NEXT; g++) begin : g_pin
      irqc_pin_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_pin[g]),
        .fall (ext_fall[g])
      );
    end
  endgenerate

  assign hw_set = {rtc_tick, tb_tick, tmr_ovf, ext_fall[1], ext_fall[0]};
  assign pend   = flag_q & en_q;

  irqc_prio #(.N(NSRC), .IW(IDX_W)) u_prio (
    .pend (pend),
    .any  (any_pend),
    .idx  (win_idx),
    .grant(grant)
  );

  assign irq_req = gie_q & ~stack_full & any_pend;
  assign irq_vec = any_pend ? DATA_W'(VEC_BASE) + DATA_W'(win_idx) * DATA_W'(VEC_STEP)
                            : '0;

  assign wr0     = reg_wr && (reg_addr == ADDR_W'(CTL0_ADDR));
  assign wr1     = reg_wr && (reg_addr == ADDR_W'(CTL1_ADDR));
  assign take    = irq_req & irq_ack;
  assign upd_ctl = wr0 | wr1 | take;

  // next state: software write, then acknowledge clear, then hardware set on top
  always_comb begin
    gie_n   = gie_q;
    en_n    = en_q;
    flag_sw = flag_q;
    if (wr0) begin
      gie_n            = reg_wdata[0];
      en_n[SRC_TMR:0]  = reg_wdata[3:1];
      flag_sw[SRC_TMR:0] = reg_wdata[6:4];
    end
    if (wr1) begin
      en_n[SRC_RTC:SRC_TB]    = reg_wdata[1:0];
      flag_sw[SRC_RTC:SRC_TB] = reg_wdata[5:4];
    end
    if (take) begin
      gie_n   = 1'b0;
      flag_sw = flag_sw & ~grant;
    end
    flag_n = flag_sw | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (upd_ctl) begin
        gie_q <= gie_n;
        en_q  <= en_n;
      end
      flag_q <= flag_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CTL0_ADDR)) begin
      reg_rdata[0]   = gie_q;
      reg_rdata[3:1] = en_q[SRC_TMR:0];
      reg_rdata[6:4] = flag_q[SRC_TMR:0];
    end else if (reg_addr == ADDR_W'(CTL1_ADDR)) begin
      reg_rdata[1:0] = en_q[SRC_RTC:SRC_TB];
      reg_rdata[5:4] = flag_q[SRC_RTC:SRC_TB];
    end
  end

  // R4
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gie_q && !stack_full));

  // R5
  vec_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[1:0] == 2'b00 && irq_vec >= 8'h04 && irq_vec <= 8'h14));

  // R6
  ack_gie_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> (!gie_q && !irq_req));

  // R7
  tick_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_tick || rtc_tick) |=> (flag_q[SRC_TB] || flag_q[SRC_RTC]));

  // R9
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> flag_q[SRC_TMR]);
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ext_pin;
  logic       tmr_ovf, tb_tick, rtc_tick, stack_full;
  logic [7:0] reg_addr, reg_wdata, reg_rdata, irq_vec;
  logic       reg_wr, irq_req, irq_ack;

  int n_run = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [7:0] A0 = 8'h0B;
  localparam logic [7:0] A1 = 8'h1E;

  always #10 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .tb_tick(tb_tick), .rtc_tick(rtc_tick), .stack_full(stack_full),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] ctl0(input logic [4:0] f, input logic [4:0] e, input logic g);
    return {1'b0, f[2:0], e[2:0], g};
  endfunction

  function automatic logic [7:0] ctl1(input logic [4:0] f, input logic [4:0] e);
    return {2'b00, f[4:3], 2'b00, e[4:3]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; ext_pin = 2'b11; tmr_ovf = 0; tb_tick = 0; rtc_tick = 0;
    stack_full = 0; reg_addr = 0; reg_wr = 0; reg_wdata = 0; irq_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 req", irq_req, 0);
    rd(A0, d); check("R1 ctl0", d, 0);
    rd(A1, d); check("R1 ctl1", d, 0);

    // R2 R3 R4 R5: sweep flags x enables x stack
    for (int f = 0; f < 32; f++) begin
      for (int e = 0; e < 32; e++) begin
        logic [4:0] p;
        int lo;
        wr(A0, ctl0(5'(f), 5'(e), 1'b1));
        wr(A1, ctl1(5'(f), 5'(e)));
        rd(A0, d); check("R2 readback", d, ctl0(5'(f), 5'(e), 1'b1));
        rd(A1, d); check("R3 readback", d, ctl1(5'(f), 5'(e)));
        p = 5'(f & e);
        lo = 0;
        for (int k = 4; k >= 0; k--) if (p[k]) lo = k;
        for (int s = 0; s < 2; s++) begin
          stack_full = s[0];
          #1;
          check("R4 req", irq_req, (p != 0 && s == 0) ? 1 : 0);
          if (irq_req) check("R5 vec", irq_vec, 4 + 4 * lo);
        end
        stack_full = 0;
      end
    end

    // R3 other address: read zero, write ignored
    wr(A0, 8'h7F); wr(A1, 8'h33);
    wr(8'h0C, 8'h00);
    rd(8'h0C, d); check("R3 other read", d, 0);
    rd(A0, d); check("R3 other write ctl0", d, 8'h7F);
    rd(A1, d); check("R3 other write ctl1", d, 8'h33);

    // R2 global enable off blocks request
    wr(A0, 8'h7E); #1 check("R2 gie off", irq_req, 0);

    // R6 ack: flags ext1,tmr,rtc; winner ext1 (0x08)
    wr(A0, ctl0(5'b10110, 5'b11111, 1'b1));
    wr(A1, ctl1(5'b10110, 5'b11111));
    #1 check("R6 vec before", irq_vec, 8'h08);
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
    rd(A0, d); check("R6 ctl0 after ack", d, ctl0(5'b10100, 5'b11111, 1'b0));
    rd(A1, d); check("R6 ctl1 after ack", d, ctl1(5'b10100, 5'b11111));
    check("R6 req after ack", irq_req, 0);
    // R6 ack without request ignored
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
    rd(A0, d); check("R6 stray ack", d, ctl0(5'b10100, 5'b11111, 1'b0));

    // R7 strobes with enables off
    wr(A0, 8'h00); wr(A1, 8'h00);
    @(negedge clk); tmr_ovf = 1; tb_tick = 1; rtc_tick = 1;
    @(negedge clk); tmr_ovf = 0; tb_tick = 0; rtc_tick = 0;
    rd(A0, d); check("R7 timer flag", d, 8'h40);
    rd(A1, d); check("R7 tick flags", d, 8'h30);

    // R9 hardware set vs software write 0
    wr(A0, 8'h00);
    @(negedge clk); reg_addr = A0; reg_wdata = 8'h00; reg_wr = 1; tmr_ovf = 1;
    @(negedge clk); reg_wr = 0; tmr_ovf = 0;
    rd(A0, d); check("R9 set beats write", d, 8'h40);

    // R9 hardware set vs acknowledge clear on timer
    wr(A1, 8'h00);
    wr(A0, 8'h49);
    #1 check("R9 vec timer", irq_vec, 8'h0C);
    @(negedge clk); irq_ack = 1; tmr_ovf = 1;
    @(negedge clk); irq_ack = 0; tmr_ovf = 0;
    rd(A0, d); check("R9 set beats ack", d, 8'h48);

    // R10 software trigger of real-time clock
    wr(A0, 8'h01); wr(A1, 8'h22);
    #1 check("R10 req", irq_req, 1);
    check("R10 vec", irq_vec, 8'h14);
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
    rd(A1, d); check("R10 flag cleared", d, 8'h02);

    // R8 external pin 1 falling edge, three-edge latency
    wr(A0, 8'h00); wr(A1, 8'h00);
    @(negedge clk); ext_pin[1] = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(A0, d); check("R8 not yet", d, 8'h00);
    @(negedge clk);
    rd(A0, d); check("R8 ext1 flag", d, 8'h20);
    wr(A0, 8'h00);
    // R8 rising edge sets nothing
    @(negedge clk); ext_pin[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(A0, d); check("R8 rising ignored", d, 8'h00);
    // R8 external pin 0
    @(negedge clk); ext_pin[0] = 1'b0;
    repeat (3) @(negedge clk);
    rd(A0, d); check("R8 ext0 flag", d, 8'h10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule